// File: doc/BRIEF.md
# System-Bus Frame and Multiframe Sync Timebase

This block keeps the bit, timeslot and frame position of a serial system bus. One counter chain counts bit positions inside a frame and frames inside a multiframe. It raises a one-clock frame strobe when the bit count equals a programmable offset. It raises a multiframe strobe when that same bit position falls in frame zero. With 193 or 256 bits per frame at the bus rate, the frame strobe repeats every 125 µs. With 48 frames per multiframe, the multiframe strobe repeats every 6 ms.

Each of the two sync pins has its own direction control. When a pin drives, it carries its strobe. When a pin senses, its driver is switched off and a rising edge on it re-anchors the counter chain to the programmed offset. A multiframe edge also returns the frame index to zero. If no further edges arrive, the chain keeps counting at the nominal period from the new anchor.

Top module: `sync_timebase`

## Requirements
- R1: During and right after reset, the bit count, timeslot count and frame index are all zero.
- R2: With no realignment, the bit count steps by one each clock from 0 to BITS_PER_FRAME-1 and then wraps to 0. The frame index advances by one on each wrap and returns to 0 after frame FRAMES_PER_MF-1.
- R3: The frame strobe is high for exactly one clock whenever the bit count equals the offset input. It repeats every BITS_PER_FRAME clocks.
- R4: The multiframe strobe is high only in a cycle where the frame strobe is high and the frame index is 0. It repeats every BITS_PER_FRAME*FRAMES_PER_MF clocks.
- R5: A direction bit of 0 means drive: the pin output equals its strobe and its output enable is 1. A direction bit of 1 means sense: the pin output and its enable are both 0, while the internal strobe is still produced.
- R6: Frame pin in sense mode: if the pin is sampled low at one clock edge and high at the next, the bit count equals the offset after the edge that follows. The frame index is left unchanged by that reload.
- R7: Multiframe pin in sense mode: the same edge timing as R6 loads the bit count with the offset and sets the frame index to 0.
- R8: A sense pin that stays high causes only one realignment. Afterwards the chain flywheels at the frame and multiframe periods from the new anchor.
- R9: Edges on a pin set to drive have no effect on the counters.
- R10: The timeslot count equals the bit count divided by 8, rounded down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ofs_i | input | BW | Bit offset at which the strobes fire (must be below BITS_PER_FRAME) |
| fs_dir_i | input | 1 | Frame pin direction: 0 drive, 1 sense |
| ms_dir_i | input | 1 | Multiframe pin direction: 0 drive, 1 sense |
| fs_pin_i | input | 1 | Frame sync pin level as received |
| ms_pin_i | input | 1 | Multiframe sync pin level as received |
| fs_o | output | 1 | Frame sync pin output value |
| fs_oe_o | output | 1 | Frame sync pin output enable |
| ms_o | output | 1 | Multiframe sync pin output value |
| ms_oe_o | output | 1 | Multiframe sync pin output enable |
| fs_strb_o | output | 1 | Internal frame strobe |
| ms_strb_o | output | 1 | Internal multiframe strobe |
| bit_cnt_o | output | BW | Bit position in the frame |
| slot_cnt_o | output | BW-3 | Timeslot position in the frame |
| frame_cnt_o | output | FW | Frame index in the multiframe |

## Verification
The bench uses the default build: 193 bits per frame and 48 frames per multiframe. Because 193 is not a power of two, the bit wrap cannot hide behind a natural counter rollover. A full 9264-clock multiframe fits inside the run twice, so the multiframe flywheel is observed before and after an external anchor. The offset is tested at 5 and at 192, the last bit position, so a multiframe reload lands one clock before a frame wrap.

// File: rtl/stb_pkg.sv
// Shared types for the sync timebase.
// Assumes: nothing beyond a standard SystemVerilog compile.
package stb_pkg;
    // Direction of a sync pin as seen by the timebase
    typedef enum logic {
        PIN_DRIVE = 1'b0,
        PIN_SENSE = 1'b1
    } pin_mode_e;
endpackage

// File: rtl/stb_edge_det.sv
// Two-flop sampler and rising-edge detector for one sync pin.
// Assumes the pin level is already synchronous to clk. The detector
// yields at most one pulse per low-to-high transition, and only while
// en is high.
module stb_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pin,
    output logic rise
);
    logic s1;
    logic s2;

    // Sample the pin and keep its previous sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
        end
    end

    // A transition seen between the two samples is an edge
    assign rise = en & s1 & ~s2;
endmodule

// File: rtl/stb_bit_ctr.sv
// Bit position counter within one frame, reloadable.
// Assumes load_val < BITS_PER_FRAME. The wrap flag marks the last bit
// of a frame when no reload is taking place.
module stb_bit_ctr #(
    parameter  int BITS_PER_FRAME = 193,
    localparam int BW = $clog2(BITS_PER_FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] load_val,
    output logic [BW-1:0] cnt,
    output logic          wrap
);
    localparam logic [BW-1:0] LAST = BW'(BITS_PER_FRAME - 1);

    // Count bits, wrap at frame end, or jump to the reload value
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Frame boundary indication for the frame counter
    assign wrap = ~load & (cnt == LAST);
endmodule

// File: rtl/stb_frame_ctr.sv
// Frame index counter within one multiframe.
// Assumes adv is a one-cycle pulse per frame. clr takes priority.
module stb_frame_ctr #(
    parameter  int FRAMES_PER_MF = 48,
    localparam int FW = $clog2(FRAMES_PER_MF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [FW-1:0] cnt
);
    localparam logic [FW-1:0] LAST = FW'(FRAMES_PER_MF - 1);

    // Advance per frame, wrap at multiframe end, clear on re-anchor
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (adv)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/sync_timebase.sv
// Frame/multiframe sync timebase with flywheel.
// One counter chain (bit, then frame) either free-runs or is
// re-anchored by sensed sync edges. Strobes fire at bit position
// ofs_i. Assumes ofs_i < BITS_PER_FRAME and BITS_PER_FRAME >= 16.
module sync_timebase #(
    parameter  int BITS_PER_FRAME = 193,
    parameter  int FRAMES_PER_MF  = 48,
    localparam int BW = $clog2(BITS_PER_FRAME),
    localparam int SW = BW - 3,
    localparam int FW = $clog2(FRAMES_PER_MF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] ofs_i,
    input  logic          fs_dir_i,
    input  logic          ms_dir_i,
    input  logic          fs_pin_i,
    input  logic          ms_pin_i,
    output logic          fs_o,
    output logic          fs_oe_o,
    output logic          ms_o,
    output logic          ms_oe_o,
    output logic          fs_strb_o,
    output logic          ms_strb_o,
    output logic [BW-1:0] bit_cnt_o,
    output logic [SW-1:0] slot_cnt_o,
    output logic [FW-1:0] frame_cnt_o
);
    import stb_pkg::*;

    localparam int NPIN = 2;          // index 0: frame pin, 1: multiframe pin

    pin_mode_e           mode_v [NPIN];
    logic [NPIN-1:0]     pin_v;
    logic [NPIN-1:0]     rise_v;
    logic                reload;
    logic                wrap;
    logic [BW-1:0]       bit_cnt;
    logic [FW-1:0]       frame_cnt;

    // Pin direction and level gathering
    assign mode_v[0] = pin_mode_e'(fs_dir_i);
    assign mode_v[1] = pin_mode_e'(ms_dir_i);
    assign pin_v     = {ms_pin_i, fs_pin_i};

    // One edge detector per sync pin, enabled only in sense mode
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        stb_edge_det u_ed (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (mode_v[g] == PIN_SENSE),
            .pin  (pin_v[g]),
            .rise (rise_v[g])
        );
    end

    // Any sensed edge reloads the bit position
    assign reload = |rise_v;

    stb_bit_ctr #(.BITS_PER_FRAME(BITS_PER_FRAME)) u_bit (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (reload),
        .load_val(ofs_i),
        .cnt     (bit_cnt),
        .wrap    (wrap)
    );

    stb_frame_ctr #(.FRAMES_PER_MF(FRAMES_PER_MF)) u_frm (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (rise_v[1]),
        .adv  (wrap),
        .cnt  (frame_cnt)
    );

    // Strobes decoded from the counter chain
    assign fs_strb_o = (bit_cnt == ofs_i);
    assign ms_strb_o = fs_strb_o & (frame_cnt == '0);

    // Pin drivers, disabled in sense mode
    assign fs_oe_o = (mode_v[0] == PIN_DRIVE);
    assign ms_oe_o = (mode_v[1] == PIN_DRIVE);
    assign fs_o    = fs_oe_o & fs_strb_o;
    assign ms_o    = ms_oe_o & ms_strb_o;

    // Position outputs
    assign bit_cnt_o   = bit_cnt;
    assign slot_cnt_o  = bit_cnt[BW-1:3];
    assign frame_cnt_o = frame_cnt;
endmodule

// File: rtl/stb_chk.sv
// Property checker for sync_timebase, bound into every instance.
// Assumes the same parameters as the bound instance.
module stb_chk #(
    parameter  int BITS_PER_FRAME = 193,
    parameter  int FRAMES_PER_MF  = 48,
    localparam int BW = $clog2(BITS_PER_FRAME),
    localparam int FW = $clog2(FRAMES_PER_MF)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [BW-1:0] ofs,
    input logic          fs_dir,
    input logic          ms_dir,
    input logic          fs_o,
    input logic          fs_oe,
    input logic          ms_o,
    input logic          ms_oe,
    input logic          fs_strb,
    input logic          ms_strb,
    input logic [BW-1:0] bit_cnt,
    input logic [FW-1:0] frame_cnt,
    input logic          fs_rise,
    input logic          ms_rise
);
    localparam logic [BW-1:0] LASTB = BW'(BITS_PER_FRAME - 1);

    p_bit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= LASTB);

    p_bit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_rise && !ms_rise) |=>
        bit_cnt == (($past(bit_cnt) == LASTB) ? '0 : $past(bit_cnt) + 1'b1));

    p_frame_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_rise && bit_cnt != LASTB) |=> $stable(frame_cnt));

    p_fs_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_strb && !fs_rise && !ms_rise) |=> (!fs_strb || ofs != $past(ofs)));

    p_ms_in_fs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ms_strb |-> (fs_strb && frame_cnt == '0));

    p_fs_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fs_dir |-> (!fs_o && !fs_oe));

    p_ms_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ms_dir |-> (!ms_o && !ms_oe));

    p_fs_anchor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_rise && !ms_rise) |=>
        (bit_cnt == $past(ofs) && frame_cnt == $past(frame_cnt)));

    p_ms_anchor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ms_rise |=> (bit_cnt == $past(ofs) && frame_cnt == '0));

    p_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_rise || ms_rise) |=> (!fs_rise && !ms_rise));

    p_drive_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_dir && !ms_dir) |-> (!fs_rise && !ms_rise));
endmodule

bind sync_timebase stb_chk #(
    .BITS_PER_FRAME(BITS_PER_FRAME),
    .FRAMES_PER_MF (FRAMES_PER_MF)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ofs      (ofs_i),
    .fs_dir   (fs_dir_i),
    .ms_dir   (ms_dir_i),
    .fs_o     (fs_o),
    .fs_oe    (fs_oe_o),
    .ms_o     (ms_o),
    .ms_oe    (ms_oe_o),
    .fs_strb  (fs_strb_o),
    .ms_strb  (ms_strb_o),
    .bit_cnt  (bit_cnt_o),
    .frame_cnt(frame_cnt_o),
    .fs_rise  (rise_v[0]),
    .ms_rise  (rise_v[1])
);

// File: tb/sim_sync_timebase.sv
`timescale 1ns/1ps
// Scoreboard bench: expectations are queued with the clock count at
// which they apply. A monitor pops and compares them shortly after
// each falling edge.
module sim_sync_timebase;
    localparam int BPF = 193;
    localparam int FPM = 48;
    localparam int BW  = 8;
    localparam int SW  = 5;
    localparam int FW  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BW-1:0] ofs = 8'd5;
    logic          fs_dir = 1'b0, ms_dir = 1'b0;
    logic          fs_pin = 1'b0, ms_pin = 1'b0;
    logic          fs_o, fs_oe, ms_o, ms_oe, fs_strb, ms_strb;
    logic [BW-1:0] bit_cnt;
    logic [SW-1:0] slot_cnt;
    logic [FW-1:0] frame_cnt;

    sync_timebase #(.BITS_PER_FRAME(BPF), .FRAMES_PER_MF(FPM)) u0 (
        .clk(clk), .rst_n(rst_n), .ofs_i(ofs),
        .fs_dir_i(fs_dir), .ms_dir_i(ms_dir),
        .fs_pin_i(fs_pin), .ms_pin_i(ms_pin),
        .fs_o(fs_o), .fs_oe_o(fs_oe), .ms_o(ms_o), .ms_oe_o(ms_oe),
        .fs_strb_o(fs_strb), .ms_strb_o(ms_strb),
        .bit_cnt_o(bit_cnt), .slot_cnt_o(slot_cnt), .frame_cnt_o(frame_cnt)
    );

    always #2 clk = ~clk;   // 250 MHz

    int unsigned cyc = 0;   // rising edges since reset release
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    typedef struct {
        int unsigned at;
        int          bitv;
        int          frm;
        bit          fs, ms, fo, foe, mo, moe;
        string       req;
    } exp_t;

    exp_t sbq[$];
    int   vectors = 0;
    int   miscompares = 0;
    bit   finished = 1'b0;

    // Driver side: queue one expected observation
    task automatic expect_at(int unsigned at, int bitv, int frm, bit fs, bit ms,
                             bit fdir, bit mdir, string req);
        exp_t e;
        e.at = at; e.bitv = bitv; e.frm = frm; e.fs = fs; e.ms = ms;
        e.fo = fs & !fdir; e.foe = !fdir; e.mo = ms & !mdir; e.moe = !mdir;
        e.req = req;
        sbq.push_back(e);
    endtask

    task automatic goto(int unsigned n);
        @(negedge clk);
        while (cyc < n) @(negedge clk);
    endtask

    // Monitor: compare every expectation due at this clock count
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (rst_n && sbq.size() > 0 && sbq[0].at == cyc) begin
                exp_t e;
                e = sbq.pop_front();
                vectors++;
                if (int'(bit_cnt) != e.bitv || int'(slot_cnt) != e.bitv / 8 ||
                    int'(frame_cnt) != e.frm || fs_strb != e.fs || ms_strb != e.ms ||
                    fs_o != e.fo || fs_oe != e.foe || ms_o != e.mo || ms_oe != e.moe) begin
                    miscompares++;
                    $display("FAIL %s cyc=%0d got bit=%0d slot=%0d frame=%0d fs=%b ms=%b fo=%b foe=%b mo=%b moe=%b exp bit=%0d slot=%0d frame=%0d fs=%b ms=%b fo=%b foe=%b mo=%b moe=%b",
                             e.req, cyc, bit_cnt, slot_cnt, frame_cnt, fs_strb, ms_strb,
                             fs_o, fs_oe, ms_o, ms_oe, e.bitv, e.bitv / 8, e.frm,
                             e.fs, e.ms, e.fo, e.foe, e.mo, e.moe);
                end
            end
        end
    end

    // Stimulus and expectations
    initial begin
        // Free run from reset, offset 5
        expect_at(0,     0,   0, 0, 0, 0, 0, "R1");
        expect_at(4,     4,   0, 0, 0, 0, 0, "R3");
        expect_at(5,     5,   0, 1, 1, 0, 0, "R4");
        expect_at(6,     6,   0, 0, 0, 0, 0, "R3");
        expect_at(104,   104, 0, 0, 0, 0, 0, "R9");
        expect_at(192,   192, 0, 0, 0, 0, 0, "R2");
        expect_at(193,   0,   1, 0, 0, 0, 0, "R2");
        expect_at(198,   5,   1, 1, 0, 0, 0, "R3");
        expect_at(1000,  35,  5, 0, 0, 0, 0, "R10");
        expect_at(9269,  5,   0, 1, 1, 0, 0, "R4");
        // Frame pin sensed
        expect_at(9350,  86,  0, 0, 0, 1, 0, "R5");
        expect_at(9701,  51,  2, 0, 0, 1, 0, "R6");
        expect_at(9702,  5,   2, 1, 0, 1, 0, "R6");
        expect_at(9890,  0,   3, 0, 0, 1, 0, "R6");
        expect_at(9895,  5,   3, 1, 0, 1, 0, "R8");
        expect_at(10088, 5,   4, 1, 0, 1, 0, "R8");
        // Multiframe pin sensed, offset 192
        expect_at(10302, 192, 0, 1, 1, 1, 1, "R7");
        expect_at(10303, 0,   1, 0, 0, 1, 1, "R7");
        expect_at(10495, 192, 1, 1, 0, 1, 1, "R8");
        expect_at(19566, 192, 0, 1, 1, 1, 1, "R8");
        // Frame pin edge leaves the frame index alone
        expect_at(19701, 134, 1, 0, 0, 1, 1, "R6");
        expect_at(19702, 192, 1, 1, 0, 1, 1, "R6");
        expect_at(19703, 0,   2, 0, 0, 1, 1, "R2");
        // Frame pin back to drive
        expect_at(19895, 192, 2, 1, 0, 0, 1, "R5");

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        goto(100);   ms_pin = 1'b1;   // driven pin: edge ignored (R9)
        goto(120);   ms_pin = 1'b0;
        goto(9300);  fs_dir = 1'b1;
        goto(9700);  fs_pin = 1'b1;   // held high for 300 clocks (R8)
        goto(10000); fs_pin = 1'b0;
        goto(10100); ofs = 8'd192;
        goto(10200); ms_dir = 1'b1;
        goto(10300); ms_pin = 1'b1;
        goto(10310); ms_pin = 1'b0;
        goto(19700); fs_pin = 1'b1;
        goto(19710); fs_pin = 1'b0;
        goto(19800); fs_dir = 1'b0;
        goto(19900);
        if (sbq.size() != 0) begin
            miscompares++;
            $display("FAIL scoreboard: %0d expectations never compared (got 0 pending, exp 0)", sbq.size());
        end
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(4 * 40000);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog: got cyc=%0d, exp run end by 19900", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule